// File: doc/BRIEF.md
# Legacy INTx Message Sequencer

This block watches four level-sensitive legacy interrupt lines, indexed 0 to 3 for INTA, INTB, INTC and INTD. It keeps a record of the level last announced for each line. Whenever the present level of a line differs from that record, it issues a message request to a downstream message transmitter. A request carries the line index and a flag that marks it as an assert message (the line went high) or a deassert message (the line went low). The request is held until the transmitter acknowledges it. The block then raises a one-cycle "sent" pulse and updates its record.

Only one message is in flight at a time. When several lines differ from their record, the lowest index is served first. A line that toggles and returns to its announced level before its turn causes no message. A small side path registers a per-function pending vector: bits 0 and 1 belong to functions 0 and 1, and bits 3:2 are reserved and dropped. Building the packet, sending it on the link and routing it at the receiver are left to other blocks.

Top module: `intx_msg_seq`

## Requirements
- R1: Line index i of `irq_lines_i` (0=INTA, 1=INTB, 2=INTC, 3=INTD) is reported as the binary value i on `req_line_o`.
- R2: A 0-to-1 change on a line produces one request for that line with `req_asrt_o` = 1 (assert message).
- R3: A 1-to-0 change on a line produces one request for that line with `req_asrt_o` = 0 (deassert message).
- R4: While `req_valid_o` is high and `req_ack_i` is low, `req_valid_o`, `req_line_o` and `req_asrt_o` hold their values into the next cycle.
- R5: `sent_o` is high for exactly one cycle, the cycle after each edge at which `req_valid_o` and `req_ack_i` are both high, and is low at all other times.
- R6: At most one message is in flight, and `req_valid_o` is low while `sent_o` is high. Lines that all differ from their announced level at the same time are served in ascending index order.
- R7: A line that changes and returns to its announced level before its request is issued produces no message.
- R8: During and after a synchronous active-high reset, `req_valid_o`, `sent_o` and `pend_o` are 0 and every line is taken as announced low. A line that is high when reset is released therefore yields an assert message.
- R9: `pend_o[1:0]` equals `func_pending_i[1:0]` one cycle later. `func_pending_i[3:2]` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines_i | input | 4 | Level-sensitive interrupt lines, bit i = line i |
| func_pending_i | input | 4 | Per-function pending bits; bits 3:2 reserved |
| pend_o | output | 2 | Registered pending bits of functions 0 and 1 |
| req_valid_o | output | 1 | Message request valid, held until acknowledged |
| req_line_o | output | 2 | Line index of the requested message |
| req_asrt_o | output | 1 | 1 = assert message, 0 = deassert message |
| req_ack_i | input | 1 | Transmitter acknowledge; handshake when high with req_valid_o |
| sent_o | output | 1 | One-cycle pulse after each completed message |

## Verification
Two functions can fall in the same cycle. One is a new level change on a line. The other is a request that is held, or whose acknowledge completes, for a different line or for the same line. The bench provokes this by stalling the model transmitter while a request is outstanding. During the stall it toggles another line briefly, or flips the in-flight line back, and then releases the acknowledge. The scoreboard judges the result: the brief toggle must leave no message, the reversed line must yield a second, opposite message after the first, and the held request must not move.

// File: rtl/intx_pkg.sv
package intx_pkg;
  localparam int INTX_LINES = 4;
  localparam int INTX_IDX_W = $clog2(INTX_LINES);

  typedef enum logic [0:0] {
    ISS_IDLE = 1'b0,
    ISS_BUSY = 1'b1
  } iss_state_e;
endpackage

// File: rtl/intx_level_reg.sv
// Register chain for the incoming line levels, reset to "all low".
module intx_level_reg #(
  parameter int W      = 4,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg_q[s] <= '0;
        else     stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg_q[s] <= '0;
        else     stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/intx_prio_pick.sv
// Lowest set index wins.
module intx_prio_pick #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = i[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/intx_issuer.sv
// Compares present levels with announced levels and issues one request at a time.
module intx_issuer #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  lvl_i,
  input  logic          ack_i,
  output logic          req_valid_o,
  output logic [IW-1:0] req_line_o,
  output logic          req_asrt_o,
  output logic          sent_o
);
  import intx_pkg::*;

  iss_state_e    state_q;
  logic [N-1:0]  rep_q;
  logic [N-1:0]  diff;
  logic          pick_found;
  logic [IW-1:0] pick_idx;
  logic [IW-1:0] line_q;
  logic          asrt_q;
  logic          sent_q;

  assign diff = lvl_i ^ rep_q;

  intx_prio_pick #(.N(N), .IW(IW)) u_pick (
    .vec_i   (diff),
    .found_o (pick_found),
    .idx_o   (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ISS_IDLE;
      rep_q   <= '0;
      line_q  <= '0;
      asrt_q  <= 1'b0;
      sent_q  <= 1'b0;
    end else begin
      sent_q <= 1'b0;
      case (state_q)
        ISS_IDLE: begin
          if (pick_found) begin
            line_q  <= pick_idx;
            asrt_q  <= lvl_i[pick_idx];
            state_q <= ISS_BUSY;
          end
        end
        ISS_BUSY: begin
          if (ack_i) begin
            rep_q[line_q] <= asrt_q;
            sent_q        <= 1'b1;
            state_q       <= ISS_IDLE;
          end
        end
        default: state_q <= ISS_IDLE;
      endcase
    end
  end

  assign req_valid_o = (state_q == ISS_BUSY);
  assign req_line_o  = line_q;
  assign req_asrt_o  = asrt_q;
  assign sent_o      = sent_q;
endmodule

// File: rtl/intx_pend_reg.sv
// Registers the used per-function pending bits; reserved bits are dropped.
module intx_pend_reg #(
  parameter int IN_W = 4,
  parameter int USED = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IN_W-1:0] pend_i,
  output logic [USED-1:0] pend_o
);
  logic [USED-1:0] pend_q;
  logic            unused_rsvd;

  assign unused_rsvd = ^pend_i[IN_W-1:USED];

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_i[USED-1:0];
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/intx_msg_seq.sv
module intx_msg_seq #(
  parameter int NUM_LINES   = intx_pkg::INTX_LINES,
  parameter int IN_STAGES   = 1,
  parameter int PEND_IN_W   = 4,
  parameter int PEND_USED   = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_LINES-1:0]         irq_lines_i,
  input  logic [PEND_IN_W-1:0]         func_pending_i,
  output logic [PEND_USED-1:0]         pend_o,
  output logic                         req_valid_o,
  output logic [$clog2(NUM_LINES)-1:0] req_line_o,
  output logic                         req_asrt_o,
  input  logic                         req_ack_i,
  output logic                         sent_o
);
  localparam int IDX_W = $clog2(NUM_LINES);

  logic [NUM_LINES-1:0] lvl_q;

  intx_level_reg #(.W(NUM_LINES), .STAGES(IN_STAGES)) u_lvl (
    .clk (clk),
    .rst (rst),
    .d_i (irq_lines_i),
    .q_o (lvl_q)
  );

  intx_issuer #(.N(NUM_LINES), .IW(IDX_W)) u_iss (
    .clk         (clk),
    .rst         (rst),
    .lvl_i       (lvl_q),
    .ack_i       (req_ack_i),
    .req_valid_o (req_valid_o),
    .req_line_o  (req_line_o),
    .req_asrt_o  (req_asrt_o),
    .sent_o      (sent_o)
  );

  intx_pend_reg #(.IN_W(PEND_IN_W), .USED(PEND_USED)) u_pend (
    .clk    (clk),
    .rst    (rst),
    .pend_i (func_pending_i),
    .pend_o (pend_o)
  );
endmodule

// File: rtl/intx_msg_seq_chk.sv
module intx_msg_seq_chk #(
  parameter int NUM_LINES = 4,
  parameter int PEND_IN_W = 4,
  parameter int PEND_USED = 2
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NUM_LINES-1:0]         lvl_q,
  input logic [PEND_IN_W-1:0]         func_pending_i,
  input logic [PEND_USED-1:0]         pend_o,
  input logic                         req_valid_o,
  input logic [$clog2(NUM_LINES)-1:0] req_line_o,
  input logic                         req_asrt_o,
  input logic                         req_ack_i,
  input logic                         sent_o
);
  logic [NUM_LINES-1:0] lvl_d;

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= '0;
    else     lvl_d <= lvl_q;
  end

  // R4: request held until acknowledged
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid_o && !req_ack_i) |=> (req_valid_o && $stable(req_line_o) && $stable(req_asrt_o)));

  // R2 and R3: message kind matches the level seen when it was issued
  p_dir_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(req_valid_o) |-> (req_asrt_o == lvl_d[req_line_o]));

  // R5: handshake is followed by the sent pulse
  p_sent_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid_o && req_ack_i) |=> sent_o);

  p_sent_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    sent_o |=> !sent_o);

  p_sent_only_r5: assert property (@(posedge clk) disable iff (rst)
    !(req_valid_o && req_ack_i) |=> !sent_o);

  // R6: no new request in the pulse cycle
  p_gap_r6: assert property (@(posedge clk) disable iff (rst)
    sent_o |-> !req_valid_o);

  // R9: pending bits follow one cycle later
  p_pend_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pend_o == $past(func_pending_i[PEND_USED-1:0])));
endmodule

bind intx_msg_seq intx_msg_seq_chk #(
  .NUM_LINES (NUM_LINES),
  .PEND_IN_W (PEND_IN_W),
  .PEND_USED (PEND_USED)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .lvl_q          (lvl_q),
  .func_pending_i (func_pending_i),
  .pend_o         (pend_o),
  .req_valid_o    (req_valid_o),
  .req_line_o     (req_line_o),
  .req_asrt_o     (req_asrt_o),
  .req_ack_i      (req_ack_i),
  .sent_o         (sent_o)
);

// File: tb/intx_msg_seq_tb.sv
module intx_msg_seq_tb;
  typedef struct packed {
    logic [1:0] line;
    logic       asrt;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] irq = '0;
  logic [3:0] fpend = '0;
  logic [1:0] pend_o;
  logic       req_valid;
  logic [1:0] req_line;
  logic       req_asrt;
  logic       req_ack = 1'b0;
  logic       sent;

  intx_msg_seq u_dut (
    .clk            (clk),
    .rst            (rst),
    .irq_lines_i    (irq),
    .func_pending_i (fpend),
    .pend_o         (pend_o),
    .req_valid_o    (req_valid),
    .req_line_o     (req_line),
    .req_asrt_o     (req_asrt),
    .req_ack_i      (req_ack),
    .sent_o         (sent)
  );

  always #5 clk = ~clk;

  exp_t       q[$];
  logic [3:0] model = '0;
  int         n_chk = 0;
  int         n_fail = 0;
  int         n_push = 0;
  int         n_pop = 0;
  int         ack_delay = 1;
  bit         stall = 1'b0;
  int         wait_cnt = 0;
  exp_t       cap;
  bit         prev_valid = 1'b0;
  logic [1:0] prev_line = '0;
  logic       prev_asrt = 1'b0;
  int         cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // driver: update lines, pushing expected messages in ascending index order
  task automatic drive_lines(input logic [3:0] v);
    for (int i = 0; i < 4; i++) begin
      if (v[i] != model[i]) begin
        q.push_back(exp_t'{line: 2'(i), asrt: v[i]});
        n_push++;
      end
    end
    model = v;
    @(negedge clk);
    irq = v;
  endtask

  task automatic drain(input string tag);
    int t;
    t = 0;
    while ((q.size() != 0 || req_valid) && t < 400) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    chk(q.size() == 0, tag, q.size(), 0);
  endtask

  // monitor and transmitter model
  always @(negedge clk) begin
    if (rst) begin
      req_ack    = 1'b0;
      wait_cnt   = 0;
      prev_valid = 1'b0;
    end else if (req_ack) begin
      req_ack = 1'b0;
      chk(sent == 1'b1, "R5 sent pulse after handshake", sent, 1);
      if (q.size() == 0) begin
        chk(1'b0, "R7 unexpected message", {cap.line, cap.asrt}, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        n_pop++;
        chk(cap.line == e.line, "R1/R6 line order", cap.line, e.line);
        chk(cap.asrt == e.asrt, e.asrt ? "R2 assert flag" : "R3 deassert flag", cap.asrt, e.asrt);
      end
      prev_valid = 1'b0;
    end else begin
      if (sent) chk(1'b0, "R5 stray sent pulse", sent, 0);
      if (req_valid && prev_valid) begin
        if (req_line != prev_line || req_asrt != prev_asrt)
          chk(1'b0, "R4 request moved while held", {req_line, req_asrt}, {prev_line, prev_asrt});
      end
      prev_valid = req_valid;
      prev_line  = req_line;
      prev_asrt  = req_asrt;
      if (req_valid && !stall) begin
        if (wait_cnt >= ack_delay) begin
          req_ack  = 1'b1;
          cap      = exp_t'{line: req_line, asrt: req_asrt};
          wait_cnt = 0;
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      chk(1'b0, "watchdog expired", cyc, 20000);
      finish_run();
    end
  end

  initial begin
    // R8: reset state
    repeat (4) @(negedge clk);
    chk(req_valid == 1'b0, "R8 req_valid in reset", req_valid, 0);
    chk(sent == 1'b0, "R8 sent in reset", sent, 0);
    chk(pend_o == 2'b00, "R8 pend in reset", pend_o, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(req_valid == 1'b0, "R8 idle after reset", req_valid, 0);

    // R2, R3, R1: single line rise and fall on every line
    for (int i = 0; i < 4; i++) begin
      ack_delay = i;
      drive_lines(4'(1 << i));
      drain("R2 single rise drained");
      drive_lines(4'b0000);
      drain("R3 single fall drained");
    end

    // R6: simultaneous changes in ascending order
    ack_delay = 2;
    drive_lines(4'b1111);
    drain("R6 all rise drained");
    drive_lines(4'b0101);
    drain("R6 partial fall drained");
    drive_lines(4'b1010);
    drain("R6 mixed change drained");
    ack_delay = 0;
    drive_lines(4'b0111);
    drain("R6 back-to-back drained");
    drive_lines(4'b0000);
    drain("R6 clear drained");

    // R7 and R4: brief toggle of another line while a request is held
    stall = 1'b1;
    drive_lines(4'b0001);
    while (!req_valid) @(negedge clk);
    irq[2] = 1'b1;
    repeat (3) @(negedge clk);
    irq[2] = 1'b0;
    repeat (6) @(negedge clk);
    chk(req_valid && req_line == 2'd0, "R4 request held during stall", {req_valid, req_line}, 3'b100);
    stall = 1'b0;
    drain("R7 toggle produced no message");

    // in-flight line reverses: deassert then assert
    stall = 1'b1;
    drive_lines(4'b0000);
    while (!req_valid) @(negedge clk);
    drive_lines(4'b0001);
    repeat (4) @(negedge clk);
    stall = 1'b0;
    drain("R3/R2 reversed line drained");
    drive_lines(4'b0000);
    drain("R3 final fall drained");

    // R9: pending bits, reserved bits ignored
    fpend = 4'b1100;
    repeat (2) @(negedge clk);
    chk(pend_o == 2'b00, "R9 reserved pending bits ignored", pend_o, 0);
    chk(req_valid == 1'b0 && sent == 1'b0, "R9 reserved bits cause no message", {req_valid, sent}, 0);
    fpend = 4'b0011;
    @(negedge clk);
    chk(pend_o == 2'b11, "R9 pending follows", pend_o, 3);
    fpend = 4'b1110;
    @(negedge clk);
    chk(pend_o == 2'b10, "R9 pending follows mixed", pend_o, 2);
    fpend = 4'b0000;

    // R8: line high at reset release is announced
    rst = 1'b1;
    irq = 4'b1000;
    q.delete();
    model = 4'b0000;
    repeat (3) @(negedge clk);
    chk(req_valid == 1'b0, "R8 no request during reset with line high", req_valid, 0);
    q.push_back(exp_t'{line: 2'd3, asrt: 1'b1});
    n_push++;
    model = 4'b1000;
    rst = 1'b0;
    drain("R8 high line announced after reset");

    chk(n_push == n_pop, "R7 message count", n_pop, n_push);
    finish_run();
  end
endmodule